// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This unit steers a five-stage in-order pipeline (fetch, decode/register read, execute, memory, writeback). Each cycle it looks at the source registers of the instruction being decoded and at the destinations held in the later stages. From these it decides whether fetch and decode must wait while a no-operation enters execute. It also handles control flow. Branches are assumed not taken and are resolved in execute. When a branch is taken, the two younger wrong-path instructions are killed and fetch is steered to the target.

Exceptions are handled precisely. When a stage reports a fault, the faulting instruction and everything younger are killed, and older instructions drain normally. Fetch is steered to a fixed handler address, and the faulting PC is latched. Every control output is combinational in the cycle the condition appears. The only state is the latched exception PC.

A build-time switch selects the forwarding variant or the no-forwarding variant. With forwarding, only a load feeding the next instruction costs a bubble. Without forwarding, any pending write to a source register holds decode until the value is readable from the register file. A second switch says whether the register file can be written and read in the same cycle.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: With forwarding enabled, a valid load in execute is a load-use hazard when its nonzero destination equals a used source of a valid decoding instruction. A hazard raises pc_hold_o, fetch_hold_o and bubble_o together in that same cycle, with flush_o = 0 and redir_sel_o = 0. Exactly one bubble results, because once the load reaches memory the hazard is gone.
- R2: With forwarding enabled, a non-load writer in execute whose destination matches a source causes no stall.
- R3: With forwarding disabled, a matching writer in execute, memory or writeback stalls decode, so a dependency on the instruction just ahead costs three bubbles. If same-cycle register-file write-then-read is enabled, writeback is not checked and the cost is two bubbles.
- R4: No stall comes from destination register 0, from a source whose use flag is low, or from an invalid producer or consumer.
- R5: A taken branch (no exception accepted) sets flush_o = 4'b0011 (bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory), redir_sel_o = 1 and redir_pc_o = branch target. It raises no hold and no bubble.
- R6: An accepted exception in stage s (encoding 0 fetch, 1 decode, 2 execute, 3 memory) sets flush_o bits 0..s and clears the bits above s. It also drives redir_sel_o = 2 and redir_pc_o = TRAP_VEC.
- R7: epc_o takes exc_pc_i on the clock edge that ends a cycle with an accepted exception, and otherwise keeps its value.
- R8: Priority is accepted exception first, then taken branch, then load-use stall. A redirect cycle never holds the PC.
- R9: An exception reported from fetch or decode while a branch in execute is taken is on the wrong path. It is discarded: the branch redirect applies and epc_o is unchanged.
- R10: After reset epc_o is 0. With no requests, all control outputs are 0 and redir_sel_o = 0 (sequential).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid_i | input | 1 | Decoding instruction is valid |
| dec_rs1_i | input | 5 | First source register |
| dec_rs2_i | input | 5 | Second source register |
| dec_use_rs1_i | input | 1 | First source is read |
| dec_use_rs2_i | input | 1 | Second source is read |
| ex_valid_i | input | 1 | Execute-stage instruction valid |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| ex_is_load_i | input | 1 | Execute-stage instruction is a load |
| ex_rd_i | input | 5 | Execute-stage destination |
| mem_valid_i | input | 1 | Memory-stage instruction valid |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_rd_i | input | 5 | Memory-stage destination |
| wb_valid_i | input | 1 | Writeback-stage instruction valid |
| wb_wen_i | input | 1 | Writeback-stage instruction writes a register |
| wb_rd_i | input | 5 | Writeback-stage destination |
| br_taken_i | input | 1 | Branch in execute resolved taken |
| br_target_i | input | 32 | Branch target address |
| exc_req_i | input | 1 | Exception reported |
| exc_stage_i | input | 2 | Stage of the faulting instruction |
| exc_pc_i | input | 32 | PC of the faulting instruction |
| pc_hold_o | output | 1 | Keep the PC unchanged |
| fetch_hold_o | output | 1 | Keep the fetch/decode latch unchanged |
| bubble_o | output | 1 | Zero the controls entering execute |
| flush_o | output | 4 | Kill the instruction in fetch, decode, execute, memory (bits 0..3) |
| redir_sel_o | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 handler |
| redir_pc_o | output | 32 | Redirect address |
| epc_o | output | 32 | Latched faulting PC |

## Verification
Some properties are checked on every cycle: the three stall outputs rise together and never during a redirect; the flush mask is always a contiguous run from the fetch end; a memory-stage fault beats any branch; a younger fault under a taken branch is dropped; and the exception PC is captured exactly when a trap is taken and is stable otherwise. Stall length cannot be judged from a single cycle. The one-, two- and three-bubble costs, and the zero cost of register 0 or a non-load producer, only show up in bench scenarios that move a producer down a modelled pipeline while the consumer waits in decode. The bench also checks the full output vector against a behavioural model on every clock, over directed and randomized traffic.

// File: rtl/phc_pkg.sv
package phc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PHC_RAW  = 5;
    localparam int PHC_PCW  = 32;
    localparam int PHC_NSTG = 4;

    typedef logic [PHC_RAW-1:0] raddr_t;
    typedef logic [PHC_PCW-1:0] pc_t;

    typedef enum logic [1:0] {
        STG_IF  = 2'd0,
        STG_ID  = 2'd1,
        STG_EX  = 2'd2,
        STG_MEM = 2'd3
    } stage_e;

    typedef enum logic [1:0] {
        RDR_SEQ    = 2'd0,
        RDR_BRANCH = 2'd1,
        RDR_TRAP   = 2'd2
    } redir_e;

    typedef struct packed {
        logic   valid;
        logic   wen;
        logic   is_load;
        raddr_t rd;
    } producer_t;

    typedef struct packed {
        logic   valid;
        logic   use1;
        logic   use2;
        raddr_t rs1;
        raddr_t rs2;
    } consumer_t;

    typedef struct packed {
        logic                pc_hold;
        logic                fetch_hold;
        logic                bubble;
        logic [PHC_NSTG-1:0] flush;
        redir_e              sel;
        pc_t                 pc;
    } ctrl_t;

    // A read of register rs depends on producer p when it writes that nonzero register.
    function automatic logic src_hit(producer_t p, raddr_t rs, logic rd_en);
        return rd_en && (rs != '0) && p.valid && p.wen && (p.rd == rs);
    endfunction
endpackage

// File: rtl/phc_hazard_detect.sv
module phc_hazard_detect
    import phc_pkg::*;
#(
    parameter bit FWD_EN    = 1'b1,
    parameter bit RF_BYPASS = 1'b1
) (
    input  consumer_t dec_i,
    input  producer_t ex_i,
    input  producer_t mem_i,
    input  producer_t wb_i,
    output logic      stall_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NSRC = 2;
    // Stages that still block a reader when no forwarding paths exist.
    localparam bit CHK_MEM = !FWD_EN;
    localparam bit CHK_WB  = !FWD_EN && !RF_BYPASS;

    logic [NSRC-1:0][PHC_RAW-1:0] src;
    logic [NSRC-1:0]              src_en;
    logic [NSRC-1:0]              hit;

    assign src[0]    = dec_i.rs1;
    assign src[1]    = dec_i.rs2;
    assign src_en[0] = dec_i.valid && dec_i.use1;
    assign src_en[1] = dec_i.valid && dec_i.use2;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_src
            logic ex_hit, mem_hit, wb_hit;
            assign ex_hit  = src_hit(ex_i,  src[g], src_en[g]);
            assign mem_hit = src_hit(mem_i, src[g], src_en[g]);
            assign wb_hit  = src_hit(wb_i,  src[g], src_en[g]);
            // With forwarding only a load one step ahead cannot be bypassed.
            assign hit[g] = (ex_hit && (ex_i.is_load || !FWD_EN))
                          || (mem_hit && CHK_MEM)
                          || (wb_hit && CHK_WB);
        end
    endgenerate

    assign stall_o = |hit;
endmodule

// File: rtl/phc_squash_gen.sv
module phc_squash_gen
    import phc_pkg::*;
(
    input  logic                exc_req_i,
    input  stage_e              exc_stage_i,
    output logic [PHC_NSTG-1:0] mask_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // The faulting stage and every younger one (lower index) are killed.
    generate
        for (genvar i = 0; i < PHC_NSTG; i++) begin : g_stg
            assign mask_o[i] = exc_req_i && (int'(exc_stage_i) >= i);
        end
    endgenerate
endmodule

// File: rtl/phc_priority.sv
module phc_priority
    import phc_pkg::*;
#(
    parameter pc_t TRAP_VEC = 32'h0000_0080
) (
    input  logic                stall_i,
    input  logic                br_taken_i,
    input  pc_t                 br_target_i,
    input  logic                exc_req_i,
    input  stage_e              exc_stage_i,
    input  logic [PHC_NSTG-1:0] exc_mask_i,
    output ctrl_t               ctrl_o,
    output logic                exc_take_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // Branch resolves in execute: everything younger than execute is wrong path.
    localparam logic [PHC_NSTG-1:0] BR_FLUSH = PHC_NSTG'((1 << int'(STG_EX)) - 1);

    logic exc_older_or_same;

    // A fault in execute or beyond is not behind the branch; younger faults are wrong path.
    assign exc_older_or_same = (exc_stage_i == STG_EX) || (exc_stage_i == STG_MEM);
    assign exc_take_o        = exc_req_i && (exc_older_or_same || !br_taken_i);

    always_comb begin
        ctrl_o = '{pc_hold: 1'b0, fetch_hold: 1'b0, bubble: 1'b0,
                   flush: '0, sel: RDR_SEQ, pc: '0};
        if (exc_take_o) begin
            ctrl_o.flush = exc_mask_i;
            ctrl_o.sel   = RDR_TRAP;
            ctrl_o.pc    = TRAP_VEC;
        end else if (br_taken_i) begin
            ctrl_o.flush = BR_FLUSH;
            ctrl_o.sel   = RDR_BRANCH;
            ctrl_o.pc    = br_target_i;
        end else if (stall_i) begin
            ctrl_o.pc_hold    = 1'b1;
            ctrl_o.fetch_hold = 1'b1;
            ctrl_o.bubble     = 1'b1;
        end
    end
endmodule

// File: rtl/phc_epc_reg.sv
module phc_epc_reg
    import phc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take_i,
    input  pc_t  pc_i,
    output pc_t  epc_o
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_o <= '0;
        end else if (take_i) begin
            epc_o <= pc_i;
        end
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import phc_pkg::*;
#(
    parameter bit  FWD_EN    = 1'b1,
    parameter bit  RF_BYPASS = 1'b1,
    parameter pc_t TRAP_VEC  = 32'h0000_0080
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dec_valid_i,
    input  logic [PHC_RAW-1:0]  dec_rs1_i,
    input  logic [PHC_RAW-1:0]  dec_rs2_i,
    input  logic                dec_use_rs1_i,
    input  logic                dec_use_rs2_i,
    input  logic                ex_valid_i,
    input  logic                ex_wen_i,
    input  logic                ex_is_load_i,
    input  logic [PHC_RAW-1:0]  ex_rd_i,
    input  logic                mem_valid_i,
    input  logic                mem_wen_i,
    input  logic [PHC_RAW-1:0]  mem_rd_i,
    input  logic                wb_valid_i,
    input  logic                wb_wen_i,
    input  logic [PHC_RAW-1:0]  wb_rd_i,
    input  logic                br_taken_i,
    input  logic [PHC_PCW-1:0]  br_target_i,
    input  logic                exc_req_i,
    input  logic [1:0]          exc_stage_i,
    input  logic [PHC_PCW-1:0]  exc_pc_i,
    output logic                pc_hold_o,
    output logic                fetch_hold_o,
    output logic                bubble_o,
    output logic [PHC_NSTG-1:0] flush_o,
    output logic [1:0]          redir_sel_o,
    output logic [PHC_PCW-1:0]  redir_pc_o,
    output logic [PHC_PCW-1:0]  epc_o
);
    timeunit 1ns;
    timeprecision 1ps;

    consumer_t           dec;
    producer_t           ex_p, mem_p, wb_p;
    stage_e              exc_stage;
    logic                stall;
    logic [PHC_NSTG-1:0] exc_mask;
    ctrl_t               ctrl;
    logic                exc_take;

    assign dec       = '{valid: dec_valid_i, use1: dec_use_rs1_i, use2: dec_use_rs2_i,
                         rs1: dec_rs1_i, rs2: dec_rs2_i};
    assign ex_p      = '{valid: ex_valid_i,  wen: ex_wen_i,  is_load: ex_is_load_i, rd: ex_rd_i};
    assign mem_p     = '{valid: mem_valid_i, wen: mem_wen_i, is_load: 1'b0, rd: mem_rd_i};
    assign wb_p      = '{valid: wb_valid_i,  wen: wb_wen_i,  is_load: 1'b0, rd: wb_rd_i};
    assign exc_stage = stage_e'(exc_stage_i);

    phc_hazard_detect #(.FWD_EN(FWD_EN), .RF_BYPASS(RF_BYPASS)) u_haz (
        .dec_i   (dec),
        .ex_i    (ex_p),
        .mem_i   (mem_p),
        .wb_i    (wb_p),
        .stall_o (stall)
    );

    phc_squash_gen u_sq (
        .exc_req_i   (exc_req_i),
        .exc_stage_i (exc_stage),
        .mask_o      (exc_mask)
    );

    phc_priority #(.TRAP_VEC(TRAP_VEC)) u_pri (
        .stall_i     (stall),
        .br_taken_i  (br_taken_i),
        .br_target_i (br_target_i),
        .exc_req_i   (exc_req_i),
        .exc_stage_i (exc_stage),
        .exc_mask_i  (exc_mask),
        .ctrl_o      (ctrl),
        .exc_take_o  (exc_take)
    );

    phc_epc_reg u_epc (
        .clk    (clk),
        .rst    (rst),
        .take_i (exc_take),
        .pc_i   (exc_pc_i),
        .epc_o  (epc_o)
    );

    assign pc_hold_o    = ctrl.pc_hold;
    assign fetch_hold_o = ctrl.fetch_hold;
    assign bubble_o     = ctrl.bubble;
    assign flush_o      = ctrl.flush;
    assign redir_sel_o  = ctrl.sel;
    assign redir_pc_o   = ctrl.pc;
endmodule

// File: rtl/phc_checker.sv
module phc_checker
    import phc_pkg::*;
#(
    parameter bit  FWD_EN   = 1'b1,
    parameter pc_t TRAP_VEC = 32'h0000_0080
) (
    input logic                clk,
    input logic                rst,
    input logic                dec_valid_i,
    input logic [PHC_RAW-1:0]  dec_rs1_i,
    input logic                dec_use_rs1_i,
    input logic [PHC_RAW-1:0]  ex_rd_i,
    input logic                mem_valid_i,
    input logic                mem_wen_i,
    input logic [PHC_RAW-1:0]  mem_rd_i,
    input logic                br_taken_i,
    input logic                exc_req_i,
    input logic [1:0]          exc_stage_i,
    input logic [PHC_PCW-1:0]  exc_pc_i,
    input logic                pc_hold_o,
    input logic                fetch_hold_o,
    input logic                bubble_o,
    input logic [PHC_NSTG-1:0] flush_o,
    input logic [1:0]          redir_sel_o,
    input logic [PHC_PCW-1:0]  redir_pc_o,
    input logic [PHC_PCW-1:0]  epc_o
);
    timeunit 1ns;
    timeprecision 1ps;

    // R1
    stall_bundle_chk: assert property (@(posedge clk) disable iff (rst)
        pc_hold_o |-> (fetch_hold_o && bubble_o && flush_o == '0 && redir_sel_o == 2'd0));

    // R3
    nofwd_mem_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (!FWD_EN && dec_valid_i && dec_use_rs1_i && dec_rs1_i != '0 && mem_valid_i
         && mem_wen_i && mem_rd_i == dec_rs1_i && !br_taken_i && !exc_req_i) |-> pc_hold_o);

    // R4
    zero_dest_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (FWD_EN && ex_rd_i == '0) |-> !pc_hold_o);

    // R5
    branch_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (br_taken_i && !exc_req_i) |-> (flush_o == 4'b0011 && redir_sel_o == 2'd1));

    // R6
    flush_contig_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({1'b0, flush_o} + 5'd1));

    // R6
    trap_target_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_sel_o == 2'd2) |-> (redir_pc_o == TRAP_VEC && flush_o[0]));

    // R7
    epc_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_sel_o == 2'd2) |=> (epc_o == $past(exc_pc_i)));

    // R7
    epc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (redir_sel_o != 2'd2) |=> $stable(epc_o));

    // R8
    mem_exc_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req_i && exc_stage_i == 2'd3) |-> (redir_sel_o == 2'd2 && flush_o == 4'hF));

    // R9
    young_exc_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (exc_req_i && br_taken_i && exc_stage_i < 2'd2) |-> (redir_sel_o == 2'd1));
endmodule

bind pipe_hazard_ctrl phc_checker #(.FWD_EN(FWD_EN), .TRAP_VEC(TRAP_VEC)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dec_valid_i   (dec_valid_i),
    .dec_rs1_i     (dec_rs1_i),
    .dec_use_rs1_i (dec_use_rs1_i),
    .ex_rd_i       (ex_rd_i),
    .mem_valid_i   (mem_valid_i),
    .mem_wen_i     (mem_wen_i),
    .mem_rd_i      (mem_rd_i),
    .br_taken_i    (br_taken_i),
    .exc_req_i     (exc_req_i),
    .exc_stage_i   (exc_stage_i),
    .exc_pc_i      (exc_pc_i),
    .pc_hold_o     (pc_hold_o),
    .fetch_hold_o  (fetch_hold_o),
    .bubble_o      (bubble_o),
    .flush_o       (flush_o),
    .redir_sel_o   (redir_sel_o),
    .redir_pc_o    (redir_pc_o),
    .epc_o         (epc_o)
);

// File: tb/sim_pipe_hazard_ctrl.sv
module sim_pipe_hazard_ctrl;
    timeunit 1ns;
    timeprecision 1ps;
    import phc_pkg::*;

    localparam logic [31:0] VEC = 32'h0000_0080;

    typedef struct packed {
        logic        hold;
        logic        fhold;
        logic        bub;
        logic [3:0]  fl;
        logic [1:0]  sel;
        logic [31:0] pc;
    } obs_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic d_v, d_u1, d_u2, x_v, x_w, x_ld, m_v, m_w, w_v, w_w, br, ex_req;
    logic [4:0] d_rs1, d_rs2, x_rd, m_rd, w_rd;
    logic [31:0] br_tgt, ex_pc;
    logic [1:0] ex_st;

    logic hold0, fh0, bub0, hold1, fh1, bub1, hold2, fh2, bub2;
    logic [3:0] fl0, fl1, fl2;
    logic [1:0] sel0, sel1, sel2;
    logic [31:0] rpc0, rpc1, rpc2, epc0, epc1, epc2;
    obs_t o0, o1, o2;
    assign o0 = {hold0, fh0, bub0, fl0, sel0, rpc0};
    assign o1 = {hold1, fh1, bub1, fl1, sel1, rpc1};
    assign o2 = {hold2, fh2, bub2, fl2, sel2, rpc2};

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] exp_epc = '0;

    pipe_hazard_ctrl #(.FWD_EN(1'b1), .RF_BYPASS(1'b1), .TRAP_VEC(VEC)) u0 (
        .clk(clk), .rst(rst), .dec_valid_i(d_v), .dec_rs1_i(d_rs1), .dec_rs2_i(d_rs2),
        .dec_use_rs1_i(d_u1), .dec_use_rs2_i(d_u2), .ex_valid_i(x_v), .ex_wen_i(x_w),
        .ex_is_load_i(x_ld), .ex_rd_i(x_rd), .mem_valid_i(m_v), .mem_wen_i(m_w),
        .mem_rd_i(m_rd), .wb_valid_i(w_v), .wb_wen_i(w_w), .wb_rd_i(w_rd),
        .br_taken_i(br), .br_target_i(br_tgt), .exc_req_i(ex_req), .exc_stage_i(ex_st),
        .exc_pc_i(ex_pc), .pc_hold_o(hold0), .fetch_hold_o(fh0), .bubble_o(bub0),
        .flush_o(fl0), .redir_sel_o(sel0), .redir_pc_o(rpc0), .epc_o(epc0));

    pipe_hazard_ctrl #(.FWD_EN(1'b0), .RF_BYPASS(1'b0), .TRAP_VEC(VEC)) u1 (
        .clk(clk), .rst(rst), .dec_valid_i(d_v), .dec_rs1_i(d_rs1), .dec_rs2_i(d_rs2),
        .dec_use_rs1_i(d_u1), .dec_use_rs2_i(d_u2), .ex_valid_i(x_v), .ex_wen_i(x_w),
        .ex_is_load_i(x_ld), .ex_rd_i(x_rd), .mem_valid_i(m_v), .mem_wen_i(m_w),
        .mem_rd_i(m_rd), .wb_valid_i(w_v), .wb_wen_i(w_w), .wb_rd_i(w_rd),
        .br_taken_i(br), .br_target_i(br_tgt), .exc_req_i(ex_req), .exc_stage_i(ex_st),
        .exc_pc_i(ex_pc), .pc_hold_o(hold1), .fetch_hold_o(fh1), .bubble_o(bub1),
        .flush_o(fl1), .redir_sel_o(sel1), .redir_pc_o(rpc1), .epc_o(epc1));

    pipe_hazard_ctrl #(.FWD_EN(1'b0), .RF_BYPASS(1'b1), .TRAP_VEC(VEC)) u2 (
        .clk(clk), .rst(rst), .dec_valid_i(d_v), .dec_rs1_i(d_rs1), .dec_rs2_i(d_rs2),
        .dec_use_rs1_i(d_u1), .dec_use_rs2_i(d_u2), .ex_valid_i(x_v), .ex_wen_i(x_w),
        .ex_is_load_i(x_ld), .ex_rd_i(x_rd), .mem_valid_i(m_v), .mem_wen_i(m_w),
        .mem_rd_i(m_rd), .wb_valid_i(w_v), .wb_wen_i(w_w), .wb_rd_i(w_rd),
        .br_taken_i(br), .br_target_i(br_tgt), .exc_req_i(ex_req), .exc_stage_i(ex_st),
        .exc_pc_i(ex_pc), .pc_hold_o(hold2), .fetch_hold_o(fh2), .bubble_o(bub2),
        .flush_o(fl2), .redir_sel_o(sel2), .redir_pc_o(rpc2), .epc_o(epc2));

    // Behavioural reference: what the requirements say the outputs are for the current inputs.
    function automatic obs_t model(bit fwd, bit byp);
        obs_t r;
        bit haz;
        logic [4:0] rs;
        bit u;
        r = '0;
        haz = 1'b0;
        for (int s = 0; s < 2; s++) begin
            rs = (s == 0) ? d_rs1 : d_rs2;
            u  = (s == 0) ? d_u1 : d_u2;
            if (d_v && u && rs != 5'd0) begin
                if (x_v && x_w && x_rd == rs && (x_ld || !fwd)) haz = 1'b1;
                if (!fwd && m_v && m_w && m_rd == rs) haz = 1'b1;
                if (!fwd && !byp && w_v && w_w && w_rd == rs) haz = 1'b1;
            end
        end
        if (ex_req && (ex_st >= 2'd2 || !br)) begin
            r.sel = 2'd2;
            r.pc  = VEC;
            for (int k = 0; k < 4; k++) r.fl[k] = (k <= int'(ex_st));
        end else if (br) begin
            r.sel = 2'd1;
            r.pc  = br_tgt;
            r.fl  = 4'b0011;
        end else if (haz) begin
            r.hold = 1'b1; r.fhold = 1'b1; r.bub = 1'b1;
        end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmp(string tag, obs_t a, obs_t e, logic [31:0] ep);
        string req;
        checks++;
        if (a !== e) begin
            fails++;
            if (a.hold !== e.hold || a.fhold !== e.fhold || a.bub !== e.bub) req = "R1";
            else if (a.fl !== e.fl) req = "R6";
            else req = "R8";
            $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, tag, cyc, a, e);
        end
        checks++;
        if (ep !== exp_epc) begin
            fails++;
            $display("FAIL R7 %s epc cycle=%0d actual=%0h expected=%0h", tag, cyc, ep, exp_epc);
        end
    endtask

    // Full-vector comparison on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst) begin
            exp_epc = '0;
        end else if (!done) begin
            obs_t e0;
            e0 = model(1'b1, 1'b1);
            cmp("u0", o0, e0, epc0);
            cmp("u1", o1, model(1'b0, 1'b0), epc1);
            cmp("u2", o2, model(1'b0, 1'b1), epc2);
            if (e0.sel == 2'd2) exp_epc = ex_pc;
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        d_v = 0; d_u1 = 0; d_u2 = 0; d_rs1 = 0; d_rs2 = 0;
        x_v = 0; x_w = 0; x_ld = 0; x_rd = 0;
        m_v = 0; m_w = 0; m_rd = 0; w_v = 0; w_w = 0; w_rd = 0;
        br = 0; br_tgt = 0; ex_req = 0; ex_st = 0; ex_pc = 0;
    endtask

    // Producer one step ahead of the consumer; the producer moves on each bubble.
    task automatic count_bubbles(int which, bit ld, logic [4:0] rd, logic [4:0] rs, output int n);
        bit st;
        step();
        idle();
        x_v = 1; x_w = 1; x_ld = ld; x_rd = rd;
        d_v = 1; d_rs1 = rs; d_u1 = 1;
        n = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            st = (which == 0) ? hold0 : (which == 1) ? hold1 : hold2;
            step();
            if (!st) break;
            n++;
            w_v = m_v; w_w = m_w; w_rd = m_rd;
            m_v = x_v; m_w = x_w; m_rd = x_rd;
            x_v = 0; x_w = 0; x_ld = 0; x_rd = 0;
        end
        idle();
    endtask

    initial begin
        int n;
        idle();
        rst = 1'b1;
        repeat (3) step();
        @(negedge clk);
        // R10: reset state and idle outputs
        chk("R10 epc", epc0, 0);
        chk("R10 idle", o0, 0);
        step();
        rst = 1'b0;

        // R1: load-use with forwarding costs one bubble
        count_bubbles(0, 1'b1, 5'd7, 5'd7, n);
        chk("R1 bubbles", n, 1);
        // R2: ALU producer with forwarding costs nothing
        count_bubbles(0, 1'b0, 5'd7, 5'd7, n);
        chk("R2 bubbles", n, 0);
        // R3: no forwarding, three bubbles; with same-cycle register file, two
        count_bubbles(1, 1'b0, 5'd9, 5'd9, n);
        chk("R3 bubbles nofwd", n, 3);
        count_bubbles(2, 1'b0, 5'd9, 5'd9, n);
        chk("R3 bubbles bypass", n, 2);
        // R4: register 0 and unused sources never stall
        count_bubbles(0, 1'b1, 5'd0, 5'd0, n);
        chk("R4 r0 fwd", n, 0);
        count_bubbles(1, 1'b1, 5'd0, 5'd0, n);
        chk("R4 r0 nofwd", n, 0);
        step();
        x_v = 1; x_w = 1; x_ld = 1; x_rd = 5'd3; d_v = 1; d_rs1 = 5'd3; d_u1 = 0;
        @(negedge clk);
        chk("R4 unused src", {hold0, hold1}, 0);

        // R5: taken branch
        step(); idle();
        br = 1; br_tgt = 32'h0000_1234;
        @(negedge clk);
        chk("R5 flush", fl0, 4'b0011);
        chk("R5 sel", sel0, 1);
        chk("R5 target", rpc0, 32'h1234);
        chk("R5 no hold", {hold0, bub0}, 0);

        // R6 and R7: exception from each stage
        for (int s = 0; s < 4; s++) begin
            step(); idle();
            ex_req = 1; ex_st = 2'(s); ex_pc = 32'h100 + 32'(s);
            @(negedge clk);
            chk("R6 mask", fl0, (64'd1 << (s + 1)) - 1);
            chk("R6 sel", sel0, 2);
            chk("R6 vector", rpc0, VEC);
            step(); idle();
            @(negedge clk);
            chk("R7 epc", epc0, 32'h100 + 32'(s));
        end

        // R8: memory fault over branch, branch over load-use stall
        step(); idle();
        ex_req = 1; ex_st = 2'd3; ex_pc = 32'h200; br = 1; br_tgt = 32'h3000;
        @(negedge clk);
        chk("R8 mem exc", {sel0, fl0}, {2'd2, 4'hF});
        step(); idle();
        br = 1; br_tgt = 32'h3000;
        x_v = 1; x_w = 1; x_ld = 1; x_rd = 5'd4; d_v = 1; d_rs1 = 5'd4; d_u1 = 1;
        @(negedge clk);
        chk("R8 branch over stall", {hold0, sel0}, {1'b0, 2'd1});
        step(); idle();
        ex_req = 1; ex_st = 2'd2; ex_pc = 32'h210; br = 1; br_tgt = 32'h3000;
        @(negedge clk);
        chk("R8 ex exc", {sel0, fl0}, {2'd2, 4'h7});

        // R9: younger fault under a taken branch is dropped
        step(); idle();
        ex_req = 1; ex_st = 2'd1; ex_pc = 32'hDEAD; br = 1; br_tgt = 32'h4000;
        @(negedge clk);
        chk("R9 sel", {sel0, fl0}, {2'd1, 4'h3});
        step(); idle();
        @(negedge clk);
        chk("R9 epc kept", epc0, 32'h210);

        // Mixed traffic, checked by the per-cycle model
        for (int i = 0; i < 3000; i++) begin
            step();
            d_v = 1'($urandom_range(0, 1)); d_u1 = 1'($urandom_range(0, 1));
            d_u2 = 1'($urandom_range(0, 1));
            d_rs1 = 5'($urandom_range(0, 3)); d_rs2 = 5'($urandom_range(0, 3));
            x_v = 1'($urandom_range(0, 1)); x_w = 1'($urandom_range(0, 1));
            x_ld = 1'($urandom_range(0, 1)); x_rd = 5'($urandom_range(0, 3));
            m_v = 1'($urandom_range(0, 1)); m_w = 1'($urandom_range(0, 1));
            m_rd = 5'($urandom_range(0, 3));
            w_v = 1'($urandom_range(0, 1)); w_w = 1'($urandom_range(0, 1));
            w_rd = 5'($urandom_range(0, 3));
            br = ($urandom_range(0, 5) == 0); br_tgt = $urandom;
            ex_req = ($urandom_range(0, 7) == 0); ex_st = 2'($urandom_range(0, 3));
            ex_pc = $urandom;
        end
        step(); idle();
        repeat (2) step();
        @(negedge clk);
        finish_run();
    end
endmodule